// File: doc/BRIEF.md
# GPIO Interrupt Routing Controller

This block is a register-mapped general-purpose I/O unit of up to 32 lines, any of which can raise an interrupt. Every input line passes through a two-stage synchroniser. A per-line detector then fires on a low level, a high level, a falling edge or a rising edge. The mode comes from two per-line bits: a polarity bit and an edge-select bit. A per-line enable bit gates each detector output. A per-line route field then sends the line to one of several interrupt output wires, or to none. This lets independent lines share one output or use separate ones.

Software reaches the block over a plain single-cycle register bus. A write is taken on the clock edge where the write strobe is high. Read data comes back combinationally from the current address. The output-data and direction registers drive the pad-side outputs directly. A bypass register at 0x18 only stores a value and reads it back.

Top module: `gpio_irq_router`

## Requirements
- R1: While reset is held and after it is released, every register reads zero, and all interrupt outputs, output data and direction outputs are zero.
- R2: All register bits above the implemented line count read zero. The registers are laid out as follows:
  - 0x04 is output data and drives `gpio_out`.
  - 0x08 is direction and drives `gpio_oe`.
  - 0x0C is the interrupt enable register.
  - 0x10 is polarity.
  - 0x14 is edge-select.
  - 0x18 is the bypass store.
  - Each of these reads back its last written value, limited to the implemented lines.
  - 0x00 reads the input value after the two-stage synchroniser.
- R3: A line with its enable bit at 0 never drives any interrupt output.
- R4: Polarity 0 with edge-select 0 triggers while the synchronised input is low.
- R5: Polarity 1 with edge-select 0 triggers while the synchronised input is high.
- R6: Polarity 0 with edge-select 1 gives a one-cycle pulse when the synchronised input falls. There is no pending state.
- R7: Polarity 1 with edge-select 1 gives a one-cycle pulse when the synchronised input rises.
- R8: Route fields start at 0x20 and hold four 8-bit fields per word. Line i sits in word i/4 at bits 8*(i%4)+7 down to 8*(i%4).
  - Bit 7 of a field is route-enable.
  - Bits 4:0 of a field select the output.
  - Bits 6:5 read back as zero.
  - A line with route-enable clear, or with a select at or beyond the output count, drives no output.
- R9: Each interrupt output is the OR of all enabled, triggered lines routed to it.
- R10: An input change shows on `irq_out` after the third rising clock edge that samples it. A register write changes `irq_out` after the edge that follows the write edge.
- R11: A change of polarity or edge-select while the synchronised input is steady never creates an edge pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| gpio_in | input | NUM_LINES | Asynchronous line inputs |
| gpio_out | output | NUM_LINES | Output data register |
| gpio_oe | output | NUM_LINES | Direction register, 1 = drive |
| irq_out | output | NUM_IRQ | Registered interrupt outputs |

## Verification
An input edge is due on `irq_out` three rising edges after it is driven. It sits two edges in the synchroniser and then passes through the output register. A register write is due one edge after its own write edge. The bench drives all stimulus on falling edges and keeps a behavioural model that advances on each rising edge. It compares `irq_out` against that model at every falling edge, so every result is checked in the cycle it is due. Directed checks confirm the exact three-edge timing, the zero level during a mode change, and register readback, which is sampled 1 ns after the address settles.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned MAX_LINES = 32;
   localparam int unsigned MAX_IRQ   = 32;
   // byte offsets
   localparam int unsigned OFS_IN    = 'h00;
   localparam int unsigned OFS_OUT   = 'h04;
   localparam int unsigned OFS_DIR   = 'h08;
   localparam int unsigned OFS_EN    = 'h0C;
   localparam int unsigned OFS_POL   = 'h10;
   localparam int unsigned OFS_EDGE  = 'h14;
   localparam int unsigned OFS_BYP   = 'h18;
   localparam int unsigned OFS_ROUTE = 'h20;

   typedef struct packed {
      logic       en;
      logic [4:0] sel;
   } route_t;
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int ADDR_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic [NUM_LINES-1:0] in_sync,
   output logic [31:0]          bus_rdata,
   output logic [NUM_LINES-1:0] out_q,
   output logic [NUM_LINES-1:0] dir_q,
   output logic [NUM_LINES-1:0] en_q,
   output logic [NUM_LINES-1:0] pol_q,
   output logic [NUM_LINES-1:0] edge_q,
   output route_t [NUM_LINES-1:0] route_q
);
   localparam int ROUTE_WORDS = (NUM_LINES + 3) / 4;
   localparam int ROUTE_END   = int'(OFS_ROUTE) + 4 * ROUTE_WORDS;

   logic [NUM_LINES-1:0] byp_q;
   logic                 route_hit;
   int                   route_word;
   int                   addr_i;

   always_comb begin
      addr_i     = int'(bus_addr);
      route_hit  = (addr_i >= int'(OFS_ROUTE)) && (addr_i < ROUTE_END);
      route_word = (addr_i - int'(OFS_ROUTE)) / 4;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q   <= '0;
         dir_q   <= '0;
         en_q    <= '0;
         pol_q   <= '0;
         edge_q  <= '0;
         byp_q   <= '0;
         route_q <= '0;
      end else if (bus_wr) begin
         if (bus_addr == ADDR_W'(OFS_OUT))  out_q  <= bus_wdata[NUM_LINES-1:0];
         if (bus_addr == ADDR_W'(OFS_DIR))  dir_q  <= bus_wdata[NUM_LINES-1:0];
         if (bus_addr == ADDR_W'(OFS_EN))   en_q   <= bus_wdata[NUM_LINES-1:0];
         if (bus_addr == ADDR_W'(OFS_POL))  pol_q  <= bus_wdata[NUM_LINES-1:0];
         if (bus_addr == ADDR_W'(OFS_EDGE)) edge_q <= bus_wdata[NUM_LINES-1:0];
         if (bus_addr == ADDR_W'(OFS_BYP))  byp_q  <= bus_wdata[NUM_LINES-1:0];
         for (int i = 0; i < NUM_LINES; i++) begin
            if (route_hit && route_word == i / 4) begin
               route_q[i].en  <= bus_wdata[8*(i%4)+7];
               route_q[i].sel <= bus_wdata[8*(i%4) +: 5];
            end
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_IN))   bus_rdata[NUM_LINES-1:0] = in_sync;
      if (bus_addr == ADDR_W'(OFS_OUT))  bus_rdata[NUM_LINES-1:0] = out_q;
      if (bus_addr == ADDR_W'(OFS_DIR))  bus_rdata[NUM_LINES-1:0] = dir_q;
      if (bus_addr == ADDR_W'(OFS_EN))   bus_rdata[NUM_LINES-1:0] = en_q;
      if (bus_addr == ADDR_W'(OFS_POL))  bus_rdata[NUM_LINES-1:0] = pol_q;
      if (bus_addr == ADDR_W'(OFS_EDGE)) bus_rdata[NUM_LINES-1:0] = edge_q;
      if (bus_addr == ADDR_W'(OFS_BYP))  bus_rdata[NUM_LINES-1:0] = byp_q;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (route_hit && route_word == i / 4) begin
            bus_rdata[8*(i%4)+7]    = route_q[i].en;
            bus_rdata[8*(i%4) +: 5] = route_q[i].sel;
         end
      end
   end

   // R2: an enable-register write is visible on the next cycle
   assert_en_write_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_EN)) |=> en_q == $past(bus_wdata[NUM_LINES-1:0]));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int NUM_LINES = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pin_in,
   input  logic [NUM_LINES-1:0] pol_q,
   input  logic [NUM_LINES-1:0] edge_q,
   output logic [NUM_LINES-1:0] sync_o,
   output logic [NUM_LINES-1:0] hit_o
);
   logic [NUM_LINES-1:0] meta_q, sync_q, hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
         hist_q <= '0;
      end else begin
         meta_q <= pin_in;
         sync_q <= meta_q;
         hist_q <= sync_q;
      end
   end

   assign sync_o = sync_q;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      logic rise, fall;
      assign rise = sync_q[g] & ~hist_q[g];
      assign fall = ~sync_q[g] & hist_q[g];

      always_comb begin
         unique case ({edge_q[g], pol_q[g]})
            2'b00:   hit_o[g] = ~sync_q[g];
            2'b01:   hit_o[g] = sync_q[g];
            2'b10:   hit_o[g] = fall;
            default: hit_o[g] = rise;
         endcase
      end

      // R11: a steady synchronised input never yields an edge hit
      assert_no_spurious_R11 : assert property (@(posedge clk) disable iff (!rst_n)
         (edge_q[g] && $stable(sync_q[g])) |-> !hit_o[g]);

      // R7: with a fixed edge mode a hit lasts one cycle only
      assert_edge_single_R7 : assert property (@(posedge clk) disable iff (!rst_n)
         (edge_q[g] && hit_o[g]) |=> !(hit_o[g] && $stable(edge_q[g]) && $stable(pol_q[g])));
   end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route
   import gpio_irq_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int NUM_IRQ   = 4
) (
   input  route_t [NUM_LINES-1:0] route_q,
   input  logic   [NUM_LINES-1:0] act,
   output logic   [NUM_IRQ-1:0]   irq_o
);
   for (genvar j = 0; j < NUM_IRQ; j++) begin : g_out
      always_comb begin
         irq_o[j] = 1'b0;
         for (int i = 0; i < NUM_LINES; i++) begin
            if (act[i] && route_q[i].en && route_q[i].sel == 5'(j))
               irq_o[j] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
   import gpio_irq_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int NUM_IRQ   = 4,
   parameter int ADDR_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NUM_LINES-1:0] gpio_in,
   output logic [NUM_LINES-1:0] gpio_out,
   output logic [NUM_LINES-1:0] gpio_oe,
   output logic [NUM_IRQ-1:0]   irq_out
);
   localparam int ROUTE_END = int'(OFS_ROUTE) + 4 * ((NUM_LINES + 3) / 4);

   if (NUM_LINES < 1 || NUM_LINES > int'(MAX_LINES)) begin : g_bad_lines
      $error("NUM_LINES must lie in 1..32");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > int'(MAX_IRQ)) begin : g_bad_irq
      $error("NUM_IRQ must lie in 1..32");
   end
   if ((1 << ADDR_W) < ROUTE_END) begin : g_bad_addr
      $error("ADDR_W too narrow for the route region");
   end

   logic [NUM_LINES-1:0] en_q, pol_q, edge_q, sync_v, hit_v, act_v;
   route_t [NUM_LINES-1:0] route_q;
   logic [NUM_IRQ-1:0] irq_d, irq_q;

   gpio_irq_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .in_sync(sync_v), .bus_rdata(bus_rdata),
      .out_q(gpio_out), .dir_q(gpio_oe), .en_q(en_q), .pol_q(pol_q),
      .edge_q(edge_q), .route_q(route_q)
   );

   gpio_irq_detect #(.NUM_LINES(NUM_LINES)) u_detect (
      .clk(clk), .rst_n(rst_n), .pin_in(gpio_in), .pol_q(pol_q),
      .edge_q(edge_q), .sync_o(sync_v), .hit_o(hit_v)
   );

   assign act_v = en_q & hit_v;

   gpio_irq_route #(.NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ)) u_route (
      .route_q(route_q), .act(act_v), .irq_o(irq_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= '0;
      else        irq_q <= irq_d;
   end

   assign irq_out = irq_q;

   // R3: any active output needs an enabled, triggered line one cycle earlier
   assert_irq_needs_en_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out != '0) |-> $past((en_q & hit_v) != '0));
endmodule

// File: tb/gpio_irq_router_tb_top.sv
module gpio_irq_router_tb_top;
   localparam int N = 16;
   localparam int M = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  gpio_in = '0;
   logic [N-1:0]  gpio_out, gpio_oe;
   logic [M-1:0]  irq_out;

   always #10 clk = ~clk;

   gpio_irq_router #(.NUM_LINES(N), .NUM_IRQ(M), .ADDR_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
      .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq_out(irq_out)
   );

   int    checks = 0;
   int    fails  = 0;
   int    cyc    = 0;
   bit    cmp_on = 1'b0;
   string cur_req = "R1";

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   logic [N-1:0] m_s1, m_s2, m_s3, m_en, m_pol, m_edge;
   bit           m_ren [N];
   int           m_sel [N];
   logic [M-1:0] m_irq;

   always @(posedge clk) begin : model
      logic [M-1:0] nx;
      bit t;
      int base;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_s3 = '0;
         m_en = '0; m_pol = '0; m_edge = '0; m_irq = '0;
         for (int i = 0; i < N; i++) begin m_ren[i] = 0; m_sel[i] = 0; end
      end else begin
         nx = '0;
         for (int i = 0; i < N; i++) begin
            if (!m_edge[i]) t = m_pol[i] ? m_s2[i] : !m_s2[i];
            else t = m_pol[i] ? (m_s2[i] && !m_s3[i]) : (!m_s2[i] && m_s3[i]);
            if (t && m_en[i] && m_ren[i] && m_sel[i] < M) nx[m_sel[i]] = 1'b1;
         end
         m_irq = nx;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = gpio_in;
         if (bus_wr) begin
            if (bus_addr == 8'h0C) m_en   = bus_wdata[N-1:0];
            if (bus_addr == 8'h10) m_pol  = bus_wdata[N-1:0];
            if (bus_addr == 8'h14) m_edge = bus_wdata[N-1:0];
            if (bus_addr >= 8'h20 && int'(bus_addr) < 32 + 4 * ((N + 3) / 4)) begin
               base = (int'(bus_addr) - 32) / 4 * 4;
               for (int k = 0; k < 4; k++) begin
                  if (base + k < N) begin
                     m_ren[base+k] = bus_wdata[8*k+7];
                     m_sel[base+k] = int'(bus_wdata[8*k +: 5]);
                  end
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_on) chk(irq_out === m_irq, cur_req, 32'(irq_out), 32'(m_irq));
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         chk(1'b0, "watchdog", 32'(cyc), 32'd0);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(bus_rdata === exp, req, bus_rdata, exp);
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic toggle(input int line, input int reps);
      for (int r = 0; r < reps; r++) begin
         @(negedge clk); gpio_in[line] = ~gpio_in[line];
         wait_n(2 + r % 3);
      end
   endtask

   initial begin
      // R1: reset state
      wait_n(2);
      for (int a = 0; a <= 8'h24; a += 4) begin
         bus_addr = 8'(a); #1;
         chk(bus_rdata === 32'd0, "R1 in reset", bus_rdata, 32'd0);
      end
      chk(irq_out === '0 && gpio_out === '0 && gpio_oe === '0, "R1 outputs",
          32'(irq_out), 32'd0);
      @(negedge clk); rst_n = 1'b1;
      cmp_on = 1'b1;
      rd(8'h0C, 32'd0, "R1 after release");

      // R2: readback limited to implemented lines
      cur_req = "R2";
      wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, 32'h0000_FFFF, "R2 out");
      chk(gpio_out === 16'hFFFF, "R2 gpio_out", 32'(gpio_out), 32'hFFFF);
      wr(8'h08, 32'h1234_5A3C); rd(8'h08, 32'h0000_5A3C, "R2 dir");
      chk(gpio_oe === 16'h5A3C, "R2 gpio_oe", 32'(gpio_oe), 32'h5A3C);
      wr(8'h18, 32'hDEAD_BEEF); rd(8'h18, 32'h0000_BEEF, "R2 bypass");
      wr(8'h0C, 32'hABCD_8001); rd(8'h0C, 32'h0000_8001, "R2 enable");
      wr(8'h10, 32'h0000_00F0); rd(8'h10, 32'h0000_00F0, "R2 pol");
      wr(8'h14, 32'h0000_0F00); rd(8'h14, 32'h0000_0F00, "R2 edge");
      wr(8'h0C, 0); wr(8'h10, 0); wr(8'h14, 0);
      gpio_in = 16'hA5A5; wait_n(3);
      rd(8'h00, 32'h0000_A5A5, "R2 input sync");
      gpio_in = '0; wait_n(3);

      // R8: route fields and readback
      cur_req = "R8";
      wr(8'h20, 32'h0280_8180); rd(8'h20, 32'h0280_8180, "R8 word0");
      wr(8'h24, 32'h0060_8385); rd(8'h24, 32'h0000_8385, "R8 word1 bits6:5");

      // R4: level low on line 0 -> out0
      cur_req = "R4";
      wr(8'h0C, 32'h0001); wait_n(3);
      chk(irq_out[0] === 1'b1, "R4 low level", 32'(irq_out), 32'h1);
      toggle(0, 6);
      gpio_in[0] = 1'b0; wait_n(3);

      // R3: enable off, lines toggle, nothing fires
      cur_req = "R3";
      wr(8'h0C, 32'h0000); toggle(0, 4); toggle(1, 4);
      chk(irq_out === '0, "R3 disabled", 32'(irq_out), 32'd0);
      gpio_in = '0; wait_n(3);

      // R5: level high line 1 -> out1
      cur_req = "R5";
      wr(8'h10, 32'h0002); wr(8'h0C, 32'h0002);
      toggle(1, 6);
      gpio_in[1] = 1'b1; wait_n(3);
      chk(irq_out[1] === 1'b1, "R5 high level", 32'(irq_out), 32'h2);
      gpio_in[1] = 1'b0; wait_n(3);

      // R6: falling edge line 2 -> out0
      cur_req = "R6";
      wr(8'h10, 0); wr(8'h14, 32'h0004); wr(8'h0C, 32'h0004);
      toggle(2, 8);
      gpio_in[2] = 1'b0; wait_n(4);

      // R7: rising edge line 5 -> out3
      cur_req = "R7";
      wr(8'h10, 32'h0020); wr(8'h14, 32'h0020); wr(8'h0C, 32'h0020);
      toggle(5, 8);
      gpio_in[5] = 1'b0; wait_n(4);

      // R10: exact latency, rising edge on line 5
      cur_req = "R10";
      @(negedge clk); gpio_in[5] = 1'b1;
      @(negedge clk); chk(irq_out[3] === 1'b0, "R10 edge+1", 32'(irq_out), 32'h0);
      @(negedge clk); chk(irq_out[3] === 1'b0, "R10 edge+2", 32'(irq_out), 32'h0);
      @(negedge clk); chk(irq_out[3] === 1'b1, "R10 edge+3", 32'(irq_out), 32'h8);
      @(negedge clk); chk(irq_out[3] === 1'b0, "R10 pulse end", 32'(irq_out), 32'h0);
      gpio_in[5] = 1'b0; wait_n(4);

      // R9: lines 0 and 2 share out0, both level high
      cur_req = "R9";
      wr(8'h14, 0); wr(8'h10, 32'h0005); wr(8'h0C, 32'h0005);
      gpio_in[0] = 1'b1; wait_n(2); gpio_in[2] = 1'b1; wait_n(3);
      gpio_in[0] = 1'b0; wait_n(3);
      chk(irq_out[0] === 1'b1, "R9 shared OR", 32'(irq_out), 32'h1);
      gpio_in[2] = 1'b0; wait_n(3);
      chk(irq_out[0] === 1'b0, "R9 both low", 32'(irq_out), 32'h0);

      // R8: unrouted line 3, out-of-range line 4
      cur_req = "R8";
      wr(8'h10, 32'h0018); wr(8'h0C, 32'h0018);
      gpio_in[3] = 1'b1; gpio_in[4] = 1'b1; wait_n(4);
      chk(irq_out === '0, "R8 no route", 32'(irq_out), 32'd0);
      gpio_in = '0; wait_n(3);

      // R11: mode change with a steady high input on line 0
      cur_req = "R11";
      wr(8'h0C, 0); wr(8'h10, 32'h0001); wr(8'h14, 0);
      gpio_in[0] = 1'b1; wr(8'h0C, 32'h0001); wait_n(3);
      chk(irq_out[0] === 1'b1, "R11 level before", 32'(irq_out), 32'h1);
      wr(8'h14, 32'h0001); @(negedge clk);
      chk(irq_out[0] === 1'b0, "R11 to rising", 32'(irq_out), 32'h0);
      wr(8'h10, 32'h0000); wait_n(2);
      chk(irq_out[0] === 1'b0, "R11 to falling", 32'(irq_out), 32'h0);
      wait_n(3);

      cmp_on = 1'b0;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule